// File: doc/BRIEF.md
# Oversampled 8N1 Serial Receiver with Framing Detection

This block receives 8N1 asynchronous serial characters. A fractional divider turns the system clock into an enable tick at eight times the baud rate. The divisor is a 16-bit integer part plus an 8-bit fraction. The receive state machine only advances on that tick. It waits for the line to fall and places its first sample 12 ticks later, in the middle of data bit 0. It then takes one sample every 8 ticks for the remaining data bits and the stop bit.

A character with a good stop bit is written into an 8-entry receive FIFO as a 32-bit word, with the character in the upper byte. A low stop bit signals a framing error or a line break. In that case the character is dropped, a sticky error flag is raised, and the receiver waits for the line to go high again before it looks for a new start. The consumer reads words from the FIFO head, which is always visible at the read port, and uses the empty flag to know when data is there. A second sticky flag records characters lost to a full FIFO.

Top module: `uart8x_rx`

## Requirements
- R1: The divisor is D = div_int_i + div_frac_i/256. One oversampling tick occurs every D clocks on average, and a divisor below 1.0 behaves as 1.0. Each serial bit lasts exactly 8 ticks.
- R2: While idle, a low level on the synchronized line starts a frame. The start bit is never checked again, so a low glitch of one or two clocks followed by a high line yields the character 0xFF.
- R3: The first data sample is taken 12 ticks after the tick on which the low level was detected. Each following sample is taken 8 ticks after the previous one, so every sample lies near the middle of its bit.
- R4: Data arrives least significant bit first. Each sample enters bit 31 of a 32-bit shift register that shifts right. A pushed word therefore holds the character in bits [31:24] and zeros in bits [23:0].
- R5: A high stop sample pushes the word. The receiver can detect a new start on the very next tick, so a stop bit cut short to 6 clocks at 1 tick per clock still lets the next character through.
- R6: A low stop sample pushes nothing and raises frame_err_o. The receiver then ignores the line until it has seen a high level, so a held break produces a single error event.
- R7: frame_err_o stays at 1 until frame_clr_i is high. If frame_clr_i is high in the same cycle as a new error, the error wins.
- R8: With a fractional divisor the tick spacing alternates, so that characters sent at 8·D clocks per bit (for example D = 2.5 or 3.25) are received correctly.
- R9: The FIFO holds 8 words in order. rd_data_o always shows the oldest word, and empty_o is 1 when nothing is stored. A read pulse while the FIFO is empty has no effect.
- R10: A character that arrives while the FIFO is full is dropped and sets overflow_o. overflow_o stays at 1 until overflow_clr_i is high, and the 8 stored words are unchanged.
- R11: After reset, empty_o is 1, both flags are 0, and the receiver is idle and treats the line as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_i | input | 1 | Asynchronous serial input, idles high |
| div_int_i | input | 16 | Integer part of the clocks-per-tick divisor |
| div_frac_i | input | 8 | Fractional part of the divisor, in 1/256 steps |
| rd_en_i | input | 1 | Pops the FIFO head when the FIFO is not empty |
| rd_data_o | output | 32 | FIFO head word, character in bits [31:24] |
| empty_o | output | 1 | FIFO holds no word |
| frame_err_o | output | 1 | Sticky framing error / break flag |
| frame_clr_i | input | 1 | Clears frame_err_o; a simultaneous new error wins |
| overflow_o | output | 1 | Sticky flag: a character was lost to a full FIFO |
| overflow_clr_i | input | 1 | Clears overflow_o |

## Verification
The bench uses the default parameters: 8 ticks per bit, a first-sample wait of 12 ticks, 8 data bits, 32-bit words and an 8-deep FIFO. With the divisor at 1.0 every clock is a tick, so sample instants fall on exact clock edges. That makes three things observable at the pins: a bit window narrowed to three clocks, a stop bit cut to six clocks, and a clear held high across an error. The divisors 2.5 and 3.25 exercise the fractional accumulator at realistic oversampling. The small FIFO depth lets nine back-to-back characters reach the overflow case quickly.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int OVS_TICKS   = 8;
    localparam int FIRST_WAIT  = 12;
    localparam int DATA_BITS   = 8;
    localparam int WORD_W      = 32;
    localparam int DIV_INT_W   = 16;
    localparam int DIV_FRAC_W  = 8;
    localparam int FIFO_DEPTH  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } rx_push_t;

    function automatic logic [WORD_W-1:0] shift_in(logic [WORD_W-1:0] sr, logic b);
        return {b, sr[WORD_W-1:1]};
    endfunction
endpackage

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
    parameter int INT_W  = urx_pkg::DIV_INT_W,
    parameter int FRAC_W = urx_pkg::DIV_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    localparam int DW = INT_W + FRAC_W;
    localparam logic [DW:0] ONE = {{INT_W{1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic [DW:0] acc;
    logic [DW:0] sum;
    logic [DW:0] div_eff;

    always_comb begin
        div_eff = {1'b0, div_int, div_frac};
        if (div_eff < ONE) div_eff = ONE;
        sum = acc + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (sum >= div_eff) begin
            acc  <= sum - div_eff;
            tick <= 1'b1;
        end else begin
            acc  <= sum;
            tick <= 1'b0;
        end
    end

    // R1: once a tick fires, the remainder left in the accumulator is below one divisor
    assert_acc_below_div_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && $stable(div_int) && $stable(div_frac)) |-> (acc < div_eff));
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    output rx_push_t push,
    output logic     err_evt
);
    localparam int CW = $clog2(FIRST_WAIT);
    localparam int BW = $clog2(DATA_BITS + 1);

    logic              rx_meta, rx_s;
    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     nbits;
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_s    <= rx_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            nbits   <= '0;
            sr      <= '0;
            push    <= '0;
            err_evt <= 1'b0;
        end else begin
            push.valid <= 1'b0;
            err_evt    <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: if (!rx_s) begin
                        state <= ST_DATA;
                        cnt   <= CW'(FIRST_WAIT - 1);
                        nbits <= '0;
                        sr    <= '0;
                    end
                    ST_DATA: if (cnt == '0) begin
                        sr    <= shift_in(sr, rx_s);
                        cnt   <= CW'(OVS_TICKS - 1);
                        nbits <= nbits + 1'b1;
                        if (nbits == BW'(DATA_BITS - 1)) state <= ST_STOP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                    ST_STOP: if (cnt == '0) begin
                        if (rx_s) begin
                            push.valid <= 1'b1;
                            push.word  <= sr;
                            state      <= ST_IDLE;
                        end else begin
                            err_evt <= 1'b1;
                            state   <= ST_HOLD;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                    ST_HOLD: if (rx_s) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_word_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
        push.valid |-> (push.word[WORD_W-DATA_BITS-1:0] == '0));
    assert_bitcount_bound_R4: assert property (@(posedge clk) disable iff (rst)
        nbits <= BW'(DATA_BITS));
    assert_single_push_R5: assert property (@(posedge clk) disable iff (rst)
        push.valid |=> !push.valid);
    assert_no_push_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !push.valid);
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
    parameter int W     = urx_pkg::WORD_W,
    parameter int DEPTH = urx_pkg::FIFO_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovf_evt
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count;
    logic          full, do_wr, do_rd;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr && !full;
    assign do_rd   = rd && !empty;
    assign ovf_evt = wr && full;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));
    assert_empty_read_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (rd && empty && !wr) |=> empty);
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd) |=> full);
endmodule

// File: rtl/uart8x_rx.sv
module uart8x_rx
    import urx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rxd_i,
    input  logic [DIV_INT_W-1:0]  div_int_i,
    input  logic [DIV_FRAC_W-1:0] div_frac_i,
    input  logic                  rd_en_i,
    output logic [WORD_W-1:0]     rd_data_o,
    output logic                  empty_o,
    output logic                  frame_err_o,
    input  logic                  frame_clr_i,
    output logic                  overflow_o,
    input  logic                  overflow_clr_i
);
    logic     tick;
    rx_push_t push;
    logic     err_evt;
    logic     ovf_evt;

    urx_tick_gen #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_tick (
        .clk(clk), .rst(rst), .div_int(div_int_i), .div_frac(div_frac_i), .tick(tick)
    );

    urx_frame u_frame (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd_i), .push(push), .err_evt(err_evt)
    );

    urx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr(push.valid), .wdata(push.word), .rd(rd_en_i),
        .rdata(rd_data_o), .empty(empty_o), .ovf_evt(ovf_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_err_o <= 1'b0;
            overflow_o  <= 1'b0;
        end else begin
            if (err_evt)          frame_err_o <= 1'b1;
            else if (frame_clr_i) frame_err_o <= 1'b0;
            if (ovf_evt)             overflow_o <= 1'b1;
            else if (overflow_clr_i) overflow_o <= 1'b0;
        end
    end

    assert_frame_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_err_o && !frame_clr_i) |=> frame_err_o);
    assert_frame_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> frame_err_o);
    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !overflow_clr_i) |=> overflow_o);
    assert_no_push_with_error_R6: assert property (@(posedge clk) disable iff (rst)
        !(err_evt && push.valid));
endmodule

// File: tb/tb_uart8x_rx.sv
module tb_uart8x_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd_i = 1'b1;
    logic [15:0] div_int_i = 16'd1;
    logic [7:0]  div_frac_i = 8'd0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        empty_o, frame_err_o, overflow_o;
    logic        frame_clr_i = 1'b0;
    logic        overflow_clr_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_en = 1'b0;
    int mon_cnt = 0;

    uart8x_rx dut (
        .clk(clk), .rst(rst), .rxd_i(rxd_i), .div_int_i(div_int_i), .div_frac_i(div_frac_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
        .frame_err_o(frame_err_o), .frame_clr_i(frame_clr_i),
        .overflow_o(overflow_o), .overflow_clr_i(overflow_clr_i)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (mon_en && frame_err_o) mon_cnt++;

    function automatic logic [31:0] exp_word(logic [7:0] b);
        return {b, 24'h0};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold_line(logic lvl, int n);
        rxd_i = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] b, int bitclk, int stopclk);
        hold_line(1'b0, bitclk);
        for (int i = 0; i < 8; i++) hold_line(b[i], bitclk);
        hold_line(1'b1, stopclk);
    endtask

    task automatic pop_expect(logic [7:0] b, string tag);
        int w = 0;
        while (empty_o && w < 600) begin
            @(negedge clk);
            w++;
        end
        chk(!empty_o, tag, {31'd0, empty_o}, 32'd0);
        chk(rd_data_o == exp_word(b), tag, rd_data_o, exp_word(b));
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic pulse_clr();
        frame_clr_i = 1'b1;
        overflow_clr_i = 1'b1;
        @(negedge clk);
        frame_clr_i = 1'b0;
        overflow_clr_i = 1'b0;
    endtask

    initial begin
        logic [7:0] b;
        logic [7:0] q [$];
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(empty_o == 1'b1, "R11 empty after reset", {31'd0, empty_o}, 32'd1);
        chk(frame_err_o == 1'b0, "R11 frame flag after reset", {31'd0, frame_err_o}, 32'd0);
        chk(overflow_o == 1'b0, "R11 overflow after reset", {31'd0, overflow_o}, 32'd0);

        // R9 read while empty ignored
        rd_en_i = 1'b1;
        repeat (3) @(negedge clk);
        rd_en_i = 1'b0;
        chk(empty_o == 1'b1, "R9 empty read ignored", {31'd0, empty_o}, 32'd1);
        send_byte(8'h3C, 8, 8);
        hold_line(1'b1, 6);
        pop_expect(8'h3C, "R9 word after empty read");
        chk(empty_o == 1'b1, "R9 empty after pop", {31'd0, empty_o}, 32'd1);

        // R1 R4 random characters at one tick per clock
        for (int k = 0; k < 8; k++) begin
            b = 8'($urandom);
            send_byte(b, 8, 8);
            hold_line(1'b1, 3);
            pop_expect(b, "R4 random char div1");
        end

        // R1 divisor below one acts as one
        div_int_i = 16'd0;
        div_frac_i = 8'd100;
        b = 8'h96;
        send_byte(b, 8, 8);
        hold_line(1'b1, 4);
        pop_expect(b, "R1 divisor below one");
        div_int_i = 16'd1;
        div_frac_i = 8'd0;
        hold_line(1'b1, 4);

        // R3 only the middle three clocks of each bit carry the value
        b = 8'hA5;
        hold_line(1'b0, 8);
        for (int i = 0; i < 8; i++) begin
            hold_line(~b[i], 3);
            hold_line(b[i], 3);
            hold_line(~b[i], 2);
        end
        hold_line(1'b1, 10);
        pop_expect(b, "R3 mid-bit sampling");

        // R2 short glitch gives 0xFF
        hold_line(1'b0, 2);
        hold_line(1'b1, 90);
        pop_expect(8'hFF, "R2 glitch start");
        chk(frame_err_o == 1'b0, "R2 no error on glitch", {31'd0, frame_err_o}, 32'd0);

        // R5 shortened stop bits, back to back
        send_byte(8'h5A, 8, 6);
        send_byte(8'hC3, 8, 6);
        send_byte(8'h81, 8, 8);
        hold_line(1'b1, 4);
        pop_expect(8'h5A, "R5 short stop 1");
        pop_expect(8'hC3, "R5 short stop 2");
        pop_expect(8'h81, "R5 short stop 3");

        // R6 bad stop bit with data, then line held low
        hold_line(1'b0, 8);
        for (int i = 0; i < 8; i++) hold_line(1'b1, 8);
        hold_line(1'b0, 8);
        hold_line(1'b0, 4);
        chk(frame_err_o == 1'b1, "R6 framing error flag", {31'd0, frame_err_o}, 32'd1);
        chk(empty_o == 1'b1, "R6 no push on bad stop", {31'd0, empty_o}, 32'd1);
        pulse_clr();
        hold_line(1'b0, 120);
        chk(frame_err_o == 1'b0, "R6 waits for idle line", {31'd0, frame_err_o}, 32'd0);
        chk(empty_o == 1'b1, "R6 nothing pushed while low", {31'd0, empty_o}, 32'd1);
        hold_line(1'b1, 6);
        send_byte(8'h42, 8, 8);
        hold_line(1'b1, 4);
        pop_expect(8'h42, "R6 recovery after break");

        // R7 sticky, then set wins over a held clear
        hold_line(1'b0, 150);
        hold_line(1'b1, 10);
        repeat (20) @(negedge clk);
        chk(frame_err_o == 1'b1, "R7 flag sticky", {31'd0, frame_err_o}, 32'd1);
        pulse_clr();
        chk(frame_err_o == 1'b0, "R7 flag cleared", {31'd0, frame_err_o}, 32'd0);
        mon_cnt = 0;
        frame_clr_i = 1'b1;
        mon_en = 1'b1;
        hold_line(1'b0, 100);
        hold_line(1'b1, 10);
        mon_en = 1'b0;
        frame_clr_i = 1'b0;
        chk(mon_cnt == 1, "R7 set wins over clear", mon_cnt, 32'd1);

        // R8 fractional divisors
        div_int_i = 16'd2;
        div_frac_i = 8'd128;
        hold_line(1'b1, 20);
        for (int k = 0; k < 4; k++) begin
            b = 8'($urandom);
            send_byte(b, 20, 20);
            hold_line(1'b1, 10);
            pop_expect(b, "R8 divisor 2.5");
        end
        div_int_i = 16'd3;
        div_frac_i = 8'd64;
        hold_line(1'b1, 20);
        for (int k = 0; k < 4; k++) begin
            b = 8'($urandom);
            send_byte(b, 26, 26);
            hold_line(1'b1, 10);
            pop_expect(b, "R8 divisor 3.25");
        end
        div_int_i = 16'd1;
        div_frac_i = 8'd0;
        hold_line(1'b1, 10);

        // R10 overflow with nine characters
        q.delete();
        for (int k = 0; k < 9; k++) begin
            b = 8'($urandom);
            q.push_back(b);
            send_byte(b, 8, 8);
        end
        hold_line(1'b1, 6);
        chk(overflow_o == 1'b1, "R10 overflow flag", {31'd0, overflow_o}, 32'd1);
        for (int k = 0; k < 8; k++) pop_expect(q[k], "R10 stored words kept");
        chk(empty_o == 1'b1, "R10 ninth word dropped", {31'd0, empty_o}, 32'd1);
        chk(overflow_o == 1'b1, "R10 overflow sticky", {31'd0, overflow_o}, 32'd1);
        pulse_clr();
        chk(overflow_o == 1'b0, "R10 overflow cleared", {31'd0, overflow_o}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule